// File: doc/BRIEF.md
# Dual-Channel LED Blink Controller

This block drives two LED outputs, A and B, from a fast system clock. It also watches a slow reference clock of nominally 32.768 kHz, which keeps running in standby. Each channel holds a two-bit mode that is written through a small register port. The mode is one of dark, steady on or blinking. Both channels share one blink phase, which is divided down from the rising edges of the reference, so channels set to blink flash together. Apart from that phase, the channels share no state.

The reference is brought into the system clock domain through a synchronizer. Each of its rising edges becomes a one-cycle tick. A written mode is first parked as pending, and it becomes the active mode on the next tick. Mode changes therefore line up with the reference. If ticks stop arriving for a set number of system cycles, the reference is declared lost and blinking outputs go dark. Steady modes keep their level while the reference is lost. After reset, channel A is dark and channel B is set to blink at 1 Hz with equal high and low times. B starts blinking as soon as reference edges arrive.

Top module: `dual_led_blink`

## Requirements
- R1: While reset is asserted and right after it, both LED outputs are low. After reset, channel A is dark and channel B is in blink mode, so only B starts to flash once reference edges arrive.
- R2: The mode is held in data bits [1:0]. The codes are: 2'b00 dark, 2'b01 blink, 2'b10 dark (reserved code), 2'b11 steady high. A steady mode gives a constant output level.
- R3: A write (wr_en high) to offset 8'h5D sets the pending mode of channel A, and a write to 8'h5E sets channel B. Any other offset, or wr_en low, changes nothing. Data bits [7:2] are ignored.
- R4: A written mode becomes active only at the next reference tick; until then the previous mode keeps driving the output. The tick is consumed two system clocks after reference high is first sampled. The LED output is registered and shows the new mode one system clock after the tick is consumed.
- R5: The shared blink phase toggles once every DIV_HALF reference ticks. With the default of 16384 at 32.768 kHz, this gives 1 Hz with a 50% duty cycle, and a blinking LED is high during the high half of the phase.
- R6: If no reference tick arrives for LOSS_LIMIT system cycles, the reference is treated as lost and every blinking channel is held low, while steady modes are unaffected. The reference is also treated as lost from reset until the first tick, and any tick restores blinking.
- R7: If a write to a channel lands in the same cycle as a tick is consumed, the written value becomes active at that tick.
- R8: The channels are independent: a write to one never changes the other. Channels that are both blinking are high and low in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Slow reference clock, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register offset of the write |
| wr_data | input | 8 | Write data, mode in bits [1:0] |
| led_a | output | 1 | LED output of channel A, active high |
| led_b | output | 1 | LED output of channel B, active high |

## Verification
Two events can fall in the same system cycle: a register write and the consumption of a reference tick that commits pending modes. The bench runs a model that predicts, one edge ahead, the cycle in which a tick will be consumed. It places a write exactly on that edge and expects the new mode on the LED one clock later (R7), with the old mode still visible in the cycle in between. A second write placed one cycle after a tick must leave the output unchanged until the following tick (R4). All of this runs alongside an every-clock comparison of both LED outputs against the model.

// File: rtl/led_blink_pkg.sv
`timescale 1ns/1ps
package led_blink_pkg;

    typedef enum logic [1:0] {
        LM_OFF   = 2'b00,
        LM_BLINK = 2'b01,
        LM_RSVD  = 2'b10,
        LM_ON    = 2'b11
    } led_mode_e;

    typedef struct packed {
        logic tick;
        logic alive;
    } ref_stat_t;

    function automatic logic led_level(input led_mode_e mode,
                                       input logic phase,
                                       input logic alive);
        case (mode)
            LM_ON:    return 1'b1;
            LM_BLINK: return phase & alive;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/led_ref_monitor.sv
`timescale 1ns/1ps
module led_ref_monitor
    import led_blink_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_LIMIT  = 4096
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ref_clk_in,
    output ref_stat_t stat
);
    localparam int LW = $clog2(LOSS_LIMIT + 1);

    logic [SYNC_STAGES:0] sync_q;
    logic [LW-1:0]        quiet_q;
    logic                 alive_q;
    logic                 tick;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-1:0], ref_clk_in};
    end

    assign tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
            alive_q <= 1'b0;
        end else if (tick) begin
            quiet_q <= '0;
            alive_q <= 1'b1;
        end else if (quiet_q == LW'(LOSS_LIMIT - 1)) begin
            alive_q <= 1'b0;
        end else begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign stat.tick  = tick;
    assign stat.alive = alive_q;

    // R6: a tick always revives the reference
    p_alive_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> alive_q);
    // R4: each reference rise gives a single-cycle commit pulse
    p_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/led_blink_divider.sv
`timescale 1ns/1ps
module led_blink_divider #(
    parameter int DIV_HALF = 16384
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic phase
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q == CW'(DIV_HALF - 1)) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase = phase_q;

    // R5: count stays inside one half period
    p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < DIV_HALF);
    // R5: phase only moves on a reference tick
    p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase_q));

endmodule

// File: rtl/led_channel.sv
`timescale 1ns/1ps
module led_channel
    import led_blink_pkg::*;
#(
    parameter logic [1:0] RESET_CODE = 2'b00
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_hit,
    input  led_mode_e wr_mode,
    input  logic      tick,
    input  logic      phase,
    input  logic      alive,
    output logic      led_o
);
    led_mode_e pend_q;
    led_mode_e act_q;
    logic      led_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= led_mode_e'(RESET_CODE);
            act_q  <= led_mode_e'(RESET_CODE);
            led_q  <= 1'b0;
        end else begin
            if (wr_hit) pend_q <= wr_mode;
            if (tick)   act_q  <= wr_hit ? wr_mode : pend_q;
            led_q <= led_level(act_q, phase, alive);
        end
    end

    assign led_o = led_q;

    // R4: active mode only moves on a tick
    p_commit_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act_q));
    // R7: write coinciding with a tick is committed at once
    p_coincide_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_hit) |=> (act_q == $past(wr_mode)));
    // R2: steady high mode
    p_steady_on_r2: assert property (@(posedge clk) disable iff (rst)
        (act_q == LM_ON) |=> led_q);
    // R2: both dark codes
    p_dark_modes_r2: assert property (@(posedge clk) disable iff (rst)
        (act_q == LM_OFF || act_q == LM_RSVD) |=> !led_q);
    // R6: no blinking while the reference is lost
    p_no_blink_dead_r6: assert property (@(posedge clk) disable iff (rst)
        (act_q == LM_BLINK && !alive) |=> !led_q);

endmodule

// File: rtl/dual_led_blink.sv
`timescale 1ns/1ps
module dual_led_blink
    import led_blink_pkg::*;
#(
    parameter int         DIV_HALF     = 16384,
    parameter int         LOSS_LIMIT   = 4096,
    parameter int         SYNC_STAGES  = 2,
    parameter int         ADDR_W       = 8,
    parameter logic [7:0] OFFSET_A     = 8'h5D,
    parameter logic [7:0] OFFSET_B     = 8'h5E,
    parameter logic [1:0] RESET_MODE_A = 2'b00,
    parameter logic [1:0] RESET_MODE_B = 2'b01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              led_a,
    output logic              led_b
);
    localparam int NUM_CH = 2;
    localparam logic [NUM_CH*ADDR_W-1:0] CH_OFFS  =
        {ADDR_W'(OFFSET_B), ADDR_W'(OFFSET_A)};
    localparam logic [NUM_CH*2-1:0]      CH_RESET = {RESET_MODE_B, RESET_MODE_A};

    ref_stat_t        rstat;
    logic             phase;
    led_mode_e        wr_mode;
    logic [NUM_CH-1:0] leds;
    logic             unused_hi;

    assign wr_mode   = led_mode_e'(wr_data[1:0]);
    assign unused_hi = ^wr_data[7:2];

    led_ref_monitor #(
        .SYNC_STAGES (SYNC_STAGES),
        .LOSS_LIMIT  (LOSS_LIMIT)
    ) u_ref (
        .clk        (clk),
        .rst        (rst),
        .ref_clk_in (ref_clk_in),
        .stat       (rstat)
    );

    led_blink_divider #(
        .DIV_HALF (DIV_HALF)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .tick  (rstat.tick),
        .phase (phase)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_addr == CH_OFFS[g*ADDR_W +: ADDR_W]);

        led_channel #(
            .RESET_CODE (CH_RESET[g*2 +: 2])
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (hit),
            .wr_mode (wr_mode),
            .tick    (rstat.tick),
            .phase   (phase),
            .alive   (rstat.alive),
            .led_o   (leds[g])
        );
    end

    assign led_a = leds[0];
    assign led_b = leds[1];

    // R8: a single write never selects both channels
    p_one_target_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({g_ch[1].hit, g_ch[0].hit}));

endmodule

// File: tb/tb_dual_led_blink.sv
`timescale 1ns/1ps
module tb_dual_led_blink;
    localparam int DIV_HALF   = 4;
    localparam int LOSS_LIMIT = 20;
    localparam int REF_HALF   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_clk_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       led_a, led_b;

    int    n_run = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    ref_run = 1'b0;
    int    ref_cnt = 0;

    dual_led_blink #(
        .DIV_HALF   (DIV_HALF),
        .LOSS_LIMIT (LOSS_LIMIT)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .ref_clk_in (ref_clk_in),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .led_a      (led_a),
        .led_b      (led_b)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (ref_run) begin
            if (ref_cnt == REF_HALF - 1) begin
                ref_cnt    <= 0;
                ref_clk_in <= ~ref_clk_in;
            end else begin
                ref_cnt <= ref_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    function automatic bit want_level(input int mode, input bit ph, input bit live);
        if (mode == 3) return 1'b1;
        if (mode == 1) return ph && live;
        return 1'b0;
    endfunction

    int samples[$];
    int m_act[2], m_pend[2];
    int m_div, m_quiet;
    bit m_phase, m_alive, m_led[2], m_tick_next;

    always @(posedge clk) begin
        if (rst) begin
            samples = {0, 0, 0};
            m_act = '{0, 1};
            m_pend = '{0, 1};
            m_div = 0; m_quiet = 0;
            m_phase = 0; m_alive = 0;
            m_led = '{0, 0};
            m_tick_next = 0;
        end else begin
            bit tk;
            bit hit[2];
            tk = (samples[1] == 1) && (samples[2] == 0);
            for (int i = 0; i < 2; i++) begin
                m_led[i] = want_level(m_act[i], m_phase, m_alive);
                hit[i] = wr_en && (wr_addr == ((i == 0) ? 8'h5D : 8'h5E));
                if (tk) m_act[i] = hit[i] ? int'(wr_data[1:0]) : m_pend[i];
                if (hit[i]) m_pend[i] = int'(wr_data[1:0]);
            end
            if (tk) begin
                m_div++;
                if (m_div == DIV_HALF) begin
                    m_div = 0;
                    m_phase = !m_phase;
                end
                m_alive = 1; m_quiet = 0;
            end else if (m_quiet == LOSS_LIMIT - 1) begin
                m_alive = 0;
            end else begin
                m_quiet++;
            end
            samples.push_front(int'(ref_clk_in));
            void'(samples.pop_back());
            m_tick_next = (samples[1] == 1) && (samples[2] == 0);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk({cur_req, " led_a vs model"}, led_a, m_led[0]);
            chk({cur_req, " led_b vs model"}, led_b, m_led[1]);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int rises, a_high, hi, diff;
        logic prev_b;
        // R1 reset state
        cyc(5);
        chk("R1 reset led_a", led_a, 1'b0);
        chk("R1 reset led_b", led_b, 1'b0);
        rst = 1'b0;
        cyc(1);
        chk("R1 after reset led_b", led_b, 1'b0);
        ref_run = 1'b1;
        rises = 0; a_high = 0; prev_b = led_b;
        for (int k = 0; k < 200; k++) begin
            cyc(1);
            if (led_b && !prev_b) rises++;
            if (led_a) a_high++;
            prev_b = led_b;
        end
        chk("R1 channel B blinks by default", rises >= 2, 1'b1);
        chk("R1 channel A dark by default", a_high == 0, 1'b1);

        // R5 duty over ten full periods (2*DIV_HALF*2*REF_HALF = 48 clocks)
        cur_req = "R5";
        hi = 0;
        for (int k = 0; k < 480; k++) begin
            cyc(1);
            if (led_b) hi++;
        end
        chk("R5 50% duty", hi == 240, 1'b1);
        if (hi != 240) $display("  R5 high count %0d expected 240", hi);

        // R2 mode codes
        cur_req = "R2";
        wr(8'h5D, 8'h03); cyc(20); chk("R2 code 11 steady high", led_a, 1'b1);
        wr(8'h5D, 8'h02); cyc(20); chk("R2 code 10 dark", led_a, 1'b0);
        wr(8'h5D, 8'h03); cyc(20);
        wr(8'h5D, 8'h00); cyc(20); chk("R2 code 00 dark", led_a, 1'b0);

        // R8 both blinking in phase
        cur_req = "R8";
        wr(8'h5D, 8'h01); cyc(20);
        diff = 0;
        for (int k = 0; k < 96; k++) begin
            cyc(1);
            if (led_a !== led_b) diff++;
        end
        chk("R8 blink in phase", diff == 0, 1'b1);
        wr(8'h5D, 8'h00); cyc(20);

        // R3 address decode and ignored bits
        cur_req = "R3";
        wr(8'h5C, 8'h03); wr(8'h5F, 8'h03);
        wr_addr = 8'h5D; wr_data = 8'h03; cyc(1); wr_data = 8'h00;
        cyc(20); chk("R3 foreign offsets ignored", led_a, 1'b0);
        wr(8'h5D, 8'hFF); cyc(20); chk("R3 upper bits ignored (FF->on)", led_a, 1'b1);
        wr(8'h5D, 8'hFC); cyc(20); chk("R3 upper bits ignored (FC->off)", led_a, 1'b0);
        wr(8'h5E, 8'h03); cyc(20); chk("R3 offset 5E drives B", led_b, 1'b1);
        chk("R8 A untouched by B write", led_a, 1'b0);
        wr(8'h5E, 8'h01); cyc(20);

        // R7 write on the tick edge
        cur_req = "R7";
        while (!m_tick_next) @(negedge clk);
        wr(8'h5D, 8'h03);
        chk("R4 old mode still shown", led_a, 1'b0);
        cyc(1);
        chk("R7 coincident write committed", led_a, 1'b1);

        // R4 write just after a tick waits for the next one
        cur_req = "R4";
        while (!m_tick_next) @(negedge clk);
        cyc(1);
        wr(8'h5D, 8'h00);
        chk("R4 hold 1", led_a, 1'b1);
        cyc(1); chk("R4 hold 2", led_a, 1'b1);
        cyc(1); chk("R4 hold 3", led_a, 1'b1);
        cyc(10); chk("R4 committed at next tick", led_a, 1'b0);

        // R6 reference loss
        cur_req = "R6";
        wr(8'h5D, 8'h03); cyc(20);
        ref_run = 1'b0;
        cyc(LOSS_LIMIT + 10);
        chk("R6 blink dark on loss", led_b, 1'b0);
        chk("R6 steady high kept", led_a, 1'b1);
        wr(8'h5D, 8'h00); cyc(30);
        chk("R4 no commit without reference", led_a, 1'b1);
        ref_run = 1'b1;
        cyc(20);
        chk("R4 commit after reference returns", led_a, 1'b0);
        rises = 0; prev_b = led_b;
        for (int k = 0; k < 100; k++) begin
            cyc(1);
            if (led_b && !prev_b) rises++;
            prev_b = led_b;
        end
        chk("R6 blinking resumes", rises >= 1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule